// File: doc/BRIEF.md
# Wake Pin Controller with System-Management Interrupt

This block controls three general-purpose wake pins through two byte-wide configuration registers. One byte selects the active level of each pin. The other byte selects each pin's direction and whether that pin may raise a system-management interrupt (SMI).

A pin set as an input passes through a two-flop synchroniser and is then corrected for polarity. It is then filtered, so a new level counts only after it has held for a fixed settling window. A rising edge of the filtered, asserted level on a pin that may raise an SMI sets one shared sticky status bit, and the SMI request output follows that bit. A pin whose SMI enable is clear may instead raise a one-cycle wake event, when its external event enable allows it. A pin set as an output drives its data bit through the same polarity control.

Software writes 1 to the status bit through a strobe to clear it.

Top module: `wake_gpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both configuration bytes read 00h, `pin_oe` is 000 and `smi_req` is 0.
- R2: Address 0 is the polarity byte. Bit i (i = 0..2) set to 1 makes pin i active low, and 0 makes it active high. Bits 7:3 read 0, and writes to them are ignored.
- R3: Address 1 is the control byte. Bit i (i = 0..2) is the direction of pin i (1 = output, 0 = input), and bit 4+i is the SMI enable of pin i. Bits 7 and 3 read 0, and writes to them are ignored. Reads are combinational on `reg_addr`.
- R4: `pin_oe[i]` equals the direction bit of pin i, and `pin_out[i]` equals `pin_out_data[i]` XOR the polarity bit of pin i.
- R5: A polarity-corrected input level counts only after it has differed from the filtered level for DEB_CYCLES consecutive clocks after the two-flop synchroniser. A shorter excursion leaves the filtered level unchanged.
- R6: A rising edge of the filtered level of pin i sets the SMI status bit on the next clock when that pin is an input with its SMI enable set. `smi_req` equals the status bit.
- R7: A pin set as an output, or a pin whose SMI enable is clear, never sets the status bit.
- R8: The status bit stays set until a clock with `sts_wr_en`=1 and `sts_wr_bit0`=1. A strobe with `sts_wr_bit0`=0 has no effect, and a new qualifying edge on the same clock as a clear wins over the clear.
- R9: `wake_evt[i]` pulses for the one cycle of a filtered rising edge when pin i is an input, `evt_en[i]`=1 and its SMI enable is clear. A set SMI enable suppresses the pulse.
- R10: With the polarity bit set to 1, a falling raw pin is the asserting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = polarity byte, 1 = control byte |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Read data of the selected register |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_bit0 | input | 1 | Status write data; 1 clears the SMI status |
| pin_raw | input | 3 | Asynchronous pin levels from the pads |
| evt_en | input | 3 | Per-pin enables for the wake event path |
| pin_out_data | input | 3 | Output data for pins set as outputs |
| pin_out | output | 3 | Polarity-adjusted output level |
| pin_oe | output | 3 | Output enable per pin |
| smi_req | output | 1 | SMI request, equal to the sticky status bit |
| wake_evt | output | 3 | One-cycle wake event per pin |

## Verification
The assertions take for granted that `reg_addr` is stable whenever read data is compared against the configuration. They also take for granted that the status strobe and the register strobe are plain single-cycle pulses driven from the clock domain. Only `pin_raw` is allowed to be asynchronous. The stimulus changes every input shortly after a rising edge and holds it for whole cycles. Pin pulses are kept either clearly shorter or clearly longer than the settling window, except where the reference model is meant to follow the exact boundary.

// File: rtl/wgpio_pkg.sv
// Shared constants and types for the wake pin controller.
// Assumes a fixed three-pin layout: the register byte format depends on it.
package wgpio_pkg;
    localparam int NPINS = 3;
    localparam logic ADDR_POL = 1'b0;
    localparam logic ADDR_CTL = 1'b1;
    localparam int SMIEN_LSB = 4;
    localparam logic [7:0] POL_MASK = 8'h07;
    localparam logic [7:0] CTL_MASK = 8'h77;

    typedef struct packed {
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] smien;
    } cfg_t;
endpackage

// File: rtl/wgpio_regs.sv
// Configuration register pair. It holds the polarity byte and the control byte.
// Reserved bits are masked on write, so they always read 0.
// Assumes single-cycle write strobes synchronous to clk.
module wgpio_regs
    import wgpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output cfg_t       cfg
);
    logic [7:0] pol_byte_q;
    logic [7:0] ctl_byte_q;

    // Capture register writes, dropping reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_byte_q <= '0;
            ctl_byte_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_POL) pol_byte_q <= wr_data & POL_MASK;
            else                  ctl_byte_q <= wr_data & CTL_MASK;
        end
    end

    // Select read data and unpack configuration fields.
    always_comb begin
        rd_data   = (addr == ADDR_CTL) ? ctl_byte_q : pol_byte_q;
        cfg.pol   = pol_byte_q[NPINS-1:0];
        cfg.dir   = ctl_byte_q[NPINS-1:0];
        cfg.smien = ctl_byte_q[SMIEN_LSB +: NPINS];
    end
endmodule

// File: rtl/wgpio_pin_filter.sv
// Per-pin input path: two-flop synchroniser, polarity correction, settling filter.
// The filtered level takes a new value only after the corrected level has
// differed from it for DEB_CYCLES consecutive clocks. rise marks the cycle
// after the filtered level went from 0 to 1.
// Assumes DEB_CYCLES >= 1.
module wgpio_pin_filter #(
    parameter int DEB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    output logic filt,
    output logic rise
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic          sync1_q, sync2_q;
    logic          lvl;
    logic          filt_q, filt_d_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
        end
    end

    // Map the synchronised level to asserted-high.
    always_comb lvl = sync2_q ^ pol;

    // Count while the level differs from the filtered value, and accept at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            filt_q   <= 1'b0;
            filt_d_q <= 1'b0;
        end else begin
            filt_d_q <= filt_q;
            if (lvl != filt_q) begin
                if (cnt_q == LAST) begin
                    filt_q <= lvl;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Expose the filtered level and its rising edge.
    always_comb begin
        filt = filt_q;
        rise = filt_q & ~filt_d_q;
    end
endmodule

// File: rtl/wgpio_smi_stat.sv
// Qualifies filtered rising edges and routes each one either to the shared
// sticky SMI status or to the per-pin wake event. A new edge wins over a
// clear on the same clock.
// Assumes the status strobe is synchronous to clk.
module wgpio_smi_stat
    import wgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise,
    input  cfg_t             cfg,
    input  logic [NPINS-1:0] evt_en,
    input  logic             sts_wr_en,
    input  logic             sts_wr_bit0,
    output logic [NPINS-1:0] qual_rise,
    output logic [NPINS-1:0] wake_evt,
    output logic             smi_req
);
    logic sts_q;

    // Route edges: input pins only, with the SMI enable taking priority.
    always_comb begin
        qual_rise = rise & ~cfg.dir & cfg.smien;
        wake_evt  = rise & ~cfg.dir & ~cfg.smien & evt_en;
    end

    // Sticky status: set on a qualified edge, clear on a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sts_q <= 1'b0;
        else if (|qual_rise)             sts_q <= 1'b1;
        else if (sts_wr_en && sts_wr_bit0) sts_q <= 1'b0;
    end

    // Drive the request from the status bit.
    always_comb smi_req = sts_q;
endmodule

// File: rtl/wake_gpio_ctrl.sv
// Top of the wake pin controller. It ties the register pair, the per-pin input
// filters and the SMI status logic together, and drives the output path.
// Assumes only pin_raw is asynchronous to clk.
module wake_gpio_ctrl
    import wgpio_pkg::*;
#(
    parameter int DEB_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wr_data,
    output logic [7:0]       reg_rd_data,
    input  logic             sts_wr_en,
    input  logic             sts_wr_bit0,
    input  logic [NPINS-1:0] pin_raw,
    input  logic [NPINS-1:0] evt_en,
    input  logic [NPINS-1:0] pin_out_data,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             smi_req,
    output logic [NPINS-1:0] wake_evt
);
    cfg_t             cfg;
    logic [NPINS-1:0] filt_lvl;
    logic [NPINS-1:0] filt_rise;
    logic [NPINS-1:0] qual_rise;

    wgpio_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .cfg     (cfg)
    );

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        wgpio_pin_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pin_raw[gi]),
            .pol   (cfg.pol[gi]),
            .filt  (filt_lvl[gi]),
            .rise  (filt_rise[gi])
        );
    end

    wgpio_smi_stat u_smi (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (filt_rise),
        .cfg         (cfg),
        .evt_en      (evt_en),
        .sts_wr_en   (sts_wr_en),
        .sts_wr_bit0 (sts_wr_bit0),
        .qual_rise   (qual_rise),
        .wake_evt    (wake_evt),
        .smi_req     (smi_req)
    );

    // Output path: enable follows direction, and the level goes through polarity.
    always_comb begin
        pin_oe  = cfg.dir;
        pin_out = pin_out_data ^ cfg.pol;
    end
endmodule

// File: rtl/wgpio_checker.sv
// Property checker for wake_gpio_ctrl, attached by bind below.
module wgpio_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_addr,
    input logic [7:0] reg_rd_data,
    input logic [2:0] pin_oe,
    input logic       smi_req,
    input logic [2:0] wake_evt,
    input logic       sts_wr_en,
    input logic       sts_wr_bit0,
    input logic [2:0] qual_rise
);
    p_pol_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (reg_rd_data[7:3] == 5'b0));

    p_ctl_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b1) |-> (reg_rd_data[7] == 1'b0 && reg_rd_data[3] == 1'b0));

    p_oe_matches_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b1) |-> (pin_oe == reg_rd_data[2:0]));

    p_set_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> $past(|qual_rise));

    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|qual_rise) |=> smi_req);

    p_no_event_on_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt & pin_oe) == 3'b000);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !(sts_wr_en && sts_wr_bit0)) |=> smi_req);

    p_clear_only_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_req) |-> $past(sts_wr_en && sts_wr_bit0));

    p_event_suppressed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b1) |-> ((wake_evt & reg_rd_data[6:4]) == 3'b000));
endmodule

bind wake_gpio_ctrl wgpio_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rd_data (reg_rd_data),
    .pin_oe      (pin_oe),
    .smi_req     (smi_req),
    .wake_evt    (wake_evt),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_bit0 (sts_wr_bit0),
    .qual_rise   (qual_rise)
);

// File: tb/wake_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module wake_gpio_ctrl_tb_top;
    localparam int DEB = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       sts_wr_en = 1'b0;
    logic       sts_wr_bit0 = 1'b0;
    logic [2:0] pin_raw = '0;
    logic [2:0] evt_en = '0;
    logic [2:0] pin_out_data = '0;
    logic [2:0] pin_out, pin_oe, wake_evt;
    logic       smi_req;

    int checks = 0;
    int fails = 0;
    int wake0_count = 0;
    bit done = 1'b0;
    bit model_live = 1'b0;

    // Reference model state.
    int m_pol[3], m_dir[3], m_smi[3];
    int m_s1[3], m_s2[3], m_cnt[3], m_filt[3], m_fd[3];
    int m_sts;

    always #2 clk = ~clk;

    wake_gpio_ctrl #(.DEB_CYCLES(DEB)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .sts_wr_en(sts_wr_en), .sts_wr_bit0(sts_wr_bit0), .pin_raw(pin_raw),
        .evt_en(evt_en), .pin_out_data(pin_out_data), .pin_out(pin_out),
        .pin_oe(pin_oe), .smi_req(smi_req), .wake_evt(wake_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_pol[i] = 0; m_dir[i] = 0; m_smi[i] = 0;
                m_s1[i] = 0; m_s2[i] = 0; m_cnt[i] = 0; m_filt[i] = 0; m_fd[i] = 0;
            end
            m_sts = 0;
            model_live = 1'b1;
        end else begin
            int hit;
            hit = 0;
            for (int i = 0; i < 3; i++)
                if (m_filt[i] == 1 && m_fd[i] == 0 && m_dir[i] == 0 && m_smi[i] == 1) hit = 1;
            if (hit == 1) m_sts = 1;
            else if (sts_wr_en && sts_wr_bit0) m_sts = 0;
            for (int i = 0; i < 3; i++) begin
                int lvl;
                lvl = m_s2[i] ^ m_pol[i];
                m_fd[i] = m_filt[i];
                if (lvl != m_filt[i]) begin
                    if (m_cnt[i] == DEB - 1) begin m_filt[i] = lvl; m_cnt[i] = 0; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end else m_cnt[i] = 0;
                m_s2[i] = m_s1[i];
                m_s1[i] = int'(pin_raw[i]);
            end
            if (reg_wr_en) begin
                for (int i = 0; i < 3; i++) begin
                    if (!reg_addr) m_pol[i] = int'(reg_wr_data[i]);
                    else begin
                        m_dir[i] = int'(reg_wr_data[i]);
                        m_smi[i] = int'(reg_wr_data[4+i]);
                    end
                end
            end
        end
    end

    // Compare every output with the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && model_live) begin
            int rd, po, oe, we;
            rd = 0; po = 0; oe = 0; we = 0;
            for (int i = 0; i < 3; i++) begin
                if (!reg_addr) rd = rd | (m_pol[i] << i);
                else rd = rd | (m_dir[i] << i) | (m_smi[i] << (4 + i));
                po = po | ((int'(pin_out_data[i]) ^ m_pol[i]) << i);
                oe = oe | (m_dir[i] << i);
                if (m_filt[i] == 1 && m_fd[i] == 0 && m_dir[i] == 0 && m_smi[i] == 0 && evt_en[i])
                    we = we | (1 << i);
            end
            check(reg_addr ? "R3 rd_data" : "R2 rd_data", int'(reg_rd_data), rd);
            check("R4 pin_out", int'(pin_out), po);
            check("R4 pin_oe", int'(pin_oe), oe);
            check("R6 smi_req", int'(smi_req), m_sts);
            check("R9 wake_evt", int'(wake_evt), we);
            if (wake_evt[0]) wake0_count++;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        step();
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic clr_sts(input logic b);
        step();
        sts_wr_en = 1'b1; sts_wr_bit0 = b;
        step();
        sts_wr_en = 1'b0; sts_wr_bit0 = 1'b0;
    endtask

    task automatic peek(input logic a, input string req, input int exp);
        reg_addr = a;
        #1;
        check(req, int'(reg_rd_data), exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        peek(1'b0, "R1 pol after reset", 0);
        peek(1'b1, "R1 ctl after reset", 0);
        check("R1 smi after reset", int'(smi_req), 0);
        check("R1 oe after reset", int'(pin_oe), 0);

        // R2 / R3: reserved bits masked
        wr_reg(1'b0, 8'hFF);
        peek(1'b0, "R2 pol readback", 8'h07);
        wr_reg(1'b1, 8'hFF);
        peek(1'b1, "R3 ctl readback", 8'h77);

        // R4: output path
        wr_reg(1'b0, 8'h02);
        wr_reg(1'b1, 8'h07);
        pin_out_data = 3'b101;
        #1;
        check("R4 out level", int'(pin_out), 3'b111);
        check("R4 out enable", int'(pin_oe), 3'b111);

        // R5: short pulse ignored, then R6: held level raises SMI
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h10);
        idle(12);
        clr_sts(1'b1);
        idle(2);
        pin_raw[0] = 1'b1; idle(3); pin_raw[0] = 1'b0;
        idle(20);
        check("R5 glitch ignored", int'(smi_req), 0);
        pin_raw[0] = 1'b1;
        idle(20);
        check("R6 smi set", int'(smi_req), 1);

        // R8: write of 0 has no effect, write of 1 clears
        clr_sts(1'b0);
        idle(1);
        check("R8 write0 keeps", int'(smi_req), 1);
        clr_sts(1'b1);
        idle(1);
        check("R8 write1 clears", int'(smi_req), 0);

        // R7: output-direction pin and disabled pin
        pin_raw[0] = 1'b0; idle(20);
        wr_reg(1'b1, 8'h11);
        pin_raw[0] = 1'b1; idle(20);
        check("R7 output pin no smi", int'(smi_req), 0);
        pin_raw[0] = 1'b0; idle(20);
        wr_reg(1'b1, 8'h00);
        evt_en = 3'b001;
        wake0_count = 0;
        pin_raw[0] = 1'b1; idle(20);
        check("R7 disabled pin no smi", int'(smi_req), 0);
        check("R9 wake event pulse", wake0_count, 1);

        // R9: SMI enable suppresses the wake event
        pin_raw[0] = 1'b0; idle(20);
        wr_reg(1'b1, 8'h10);
        wake0_count = 0;
        pin_raw[0] = 1'b1; idle(20);
        check("R9 wake suppressed", wake0_count, 0);
        check("R9 smi taken instead", int'(smi_req), 1);
        evt_en = 3'b000;
        clr_sts(1'b1);

        // R10: active-low pin asserts on a falling raw edge
        wr_reg(1'b0, 8'h04);
        pin_raw[2] = 1'b1;
        wr_reg(1'b1, 8'h40);
        idle(20);
        clr_sts(1'b1);
        idle(20);
        check("R10 high raw is idle", int'(smi_req), 0);
        pin_raw[2] = 1'b0;
        idle(20);
        check("R10 falling raw asserts", int'(smi_req), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule